// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller Channel

This block is one channel of an interrupt controller. It takes up to 32 level-sensitive request lines. Each line has its own enable bit and its own 4-bit priority level. The channel picks the pending, enabled line with the highest level. When that level is strictly above a programmable permitted level, it pulls an active-low IRQ line to the processor low. At the same time it loads a readable vector register with a programmable base plus four times the winning line's index. A handler entered through the single fixed IRQ exception entry reads that register and jumps straight to one of up to 32 handlers.

Software can raise any line by setting a bit in a software-request register. That bit stays set until software clears it. A single fast-interrupt input has no arbitration: it is only synchronized, gated by an enable and driven out active-low. A wake-up output tells the clock/reset generator that an enabled request is present. It is built without a clock, so it works while clocks are stopped.

Channels cascade by wiring one channel's active-low IRQ, inverted, into a source input of another channel. By convention a second channel feeds source 6 and a third channel feeds source 5 of the first. A cascaded request therefore competes at the priority that the first channel assigns to that input. All registers sit behind an APB slave port that has no wait states.

Top module: `vpic_channel`

## Requirements
- R1: After reset, irq_no and fiq_no are high and wake_o is low. The threshold, base, enable, software-request, fast-enable and all level registers read 0.
- R2: A source takes part in arbitration only when all three hold: it is pending (its synchronized input is high or its software bit is set), its enable bit is set, and its level is nonzero. The pending register (offset 0x14, read-only) shows synchronized input OR software bits.
- R3: Among the sources that take part, the one with the highest level wins. On equal levels the lowest source index wins.
- R4: irq_no is low exactly when a winner exists and the winner's level is strictly greater than the threshold register (offset 0x00, bits [3:0]).
- R5: The vector register (offset 0x10, read-only) reads base + 4*winner index while irq_no is low, and reads base otherwise. The base register is at offset 0x04, and its bits [1:0] always read 0.
- R6: A hardware source change reaches irq_no on the third rising clock edge after the change: two synchronizer stages, then the output register. A write to the software-request register reaches irq_no on the first edge after the write's access edge.
- R7: Software-request bits (offset 0x0C, bit i for source i) take the written word and keep their value until the next write to that offset.
- R8: fiq_no goes low on the third rising edge after fiq_i rises, provided fast-enable (offset 0x18, bit 0) is set. It is high whenever fast-enable is clear. Levels and threshold have no effect on it.
- R9: wake_o is a clockless OR. It is high when any raw source input or software bit has its enable bit set, or when fiq_i is high with fast-enable set.
- R10: Enables are at offset 0x08, bit i for source i. The level of source i is at offset 0x40 + 4*i, bits [3:0]. Unmapped offsets read 0, and pready_o is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| irq_src_i | input | NUM_SRC | Level-sensitive request inputs |
| fiq_i | input | 1 | Fast-interrupt request input |
| irq_no | output | 1 | Arbitrated interrupt to processor, active low |
| fiq_no | output | 1 | Fast interrupt to processor, active low |
| wake_o | output | 1 | Wake-up request to clock controller |

## Verification
The bench builds the channel with NUM_SRC = 12, which is not a power of two. The arbitration tree is therefore padded with empty leaves, and the bench can show that those leaves never win. The 4-bit level width is kept, so random levels hit ties, level-0 sources and thresholds at both ends of the range. The address width stays at 8 bits, so every level register and a few unmapped holes can be reached.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned OFF_THRESH = 'h00;
  localparam int unsigned OFF_BASE   = 'h04;
  localparam int unsigned OFF_EN     = 'h08;
  localparam int unsigned OFF_SW     = 'h0C;
  localparam int unsigned OFF_VEC    = 'h10;
  localparam int unsigned OFF_PEND   = 'h14;
  localparam int unsigned OFF_FIQ    = 'h18;
  localparam int unsigned OFF_LVL    = 'h40;
endpackage

// File: rtl/vpic_sync.sv
module vpic_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            psel_i,
  input  logic                            penable_i,
  input  logic                            pwrite_i,
  input  logic [ADDR_W-1:0]               paddr_i,
  input  logic [REG_W-1:0]                pwdata_i,
  output logic [REG_W-1:0]                prdata_o,
  output logic [LVL_W-1:0]                thresh_o,
  output logic [REG_W-1:0]                base_o,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [NUM_SRC-1:0]              sw_o,
  output logic                            fiq_en_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o,
  input  logic [REG_W-1:0]                vec_i,
  input  logic [NUM_SRC-1:0]              pend_i
);
  localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFF_THRESH);
  localparam logic [ADDR_W-1:0] A_BASE   = ADDR_W'(OFF_BASE);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_SW     = ADDR_W'(OFF_SW);
  localparam logic [ADDR_W-1:0] A_VEC    = ADDR_W'(OFF_VEC);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_FIQ    = ADDR_W'(OFF_FIQ);

  logic wr;
  assign wr = psel_i & penable_i & pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_o <= '0;
      base_o   <= '0;
      en_o     <= '0;
      sw_o     <= '0;
      fiq_en_o <= 1'b0;
    end else if (wr) begin
      if (paddr_i == A_THRESH) thresh_o <= pwdata_i[LVL_W-1:0];
      if (paddr_i == A_BASE)   base_o   <= {pwdata_i[REG_W-1:2], 2'b00};
      if (paddr_i == A_EN)     en_o     <= pwdata_i[NUM_SRC-1:0];
      if (paddr_i == A_SW)     sw_o     <= pwdata_i[NUM_SRC-1:0];
      if (paddr_i == A_FIQ)    fiq_en_o <= pwdata_i[0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    localparam logic [ADDR_W-1:0] A_L = ADDR_W'(OFF_LVL + 4*g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_o[g] <= '0;
      else if (wr && paddr_i == A_L) lvl_o[g] <= pwdata_i[LVL_W-1:0];
    end
  end

  always_comb begin
    prdata_o = '0;
    unique case (paddr_i)
      A_THRESH: prdata_o = REG_W'(thresh_o);
      A_BASE:   prdata_o = base_o;
      A_EN:     prdata_o = REG_W'(en_o);
      A_SW:     prdata_o = REG_W'(sw_o);
      A_VEC:    prdata_o = vec_i;
      A_PEND:   prdata_o = REG_W'(pend_i);
      A_FIQ:    prdata_o = REG_W'(fiq_en_o);
      default: begin
        for (int i = 0; i < NUM_SRC; i++)
          if (paddr_i == ADDR_W'(OFF_LVL + 4*i)) prdata_o = REG_W'(lvl_o[i]);
      end
    endcase
  end
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 4,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]            req_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                          win_v_o,
  output logic [LVL_W-1:0]              win_l_o,
  output logic [IDX_W-1:0]              win_i_o
);
  localparam int unsigned N2 = 1 << IDX_W;

  // heap-ordered tree: node k has children 2k (lower indices) and 2k+1
  logic             nv [1:2*N2-1];
  logic [LVL_W-1:0] nl [1:2*N2-1];
  logic [IDX_W-1:0] ni [1:2*N2-1];

  for (genvar g = 0; g < N2; g++) begin : g_leaf
    if (g < NUM_SRC) begin : g_real
      assign nv[N2+g] = req_i[g] && (lvl_i[g] != '0);
      assign nl[N2+g] = lvl_i[g];
      assign ni[N2+g] = IDX_W'(g);
    end else begin : g_pad
      assign nv[N2+g] = 1'b0;
      assign nl[N2+g] = '0;
      assign ni[N2+g] = '0;
    end
  end

  for (genvar k = 1; k < N2; k++) begin : g_node
    logic take_r;
    // right child wins only on strictly higher level, so ties favour lower index
    assign take_r = nv[2*k+1] && (!nv[2*k] || (nl[2*k+1] > nl[2*k]));
    assign nv[k]  = nv[2*k] | nv[2*k+1];
    assign nl[k]  = take_r ? nl[2*k+1] : nl[2*k];
    assign ni[k]  = take_r ? ni[2*k+1] : ni[2*k];
  end

  assign win_v_o = nv[1];
  assign win_l_o = nl[1];
  assign win_i_o = ni[1];
endmodule

// File: rtl/vpic_channel.sv
module vpic_channel
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [31:0]        pwdata_i,
  output logic [31:0]        prdata_o,
  output logic               pready_o,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               fiq_i,
  output logic               irq_no,
  output logic               fiq_no,
  output logic               wake_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]            src_s, pend, qual, en_q, sw_q;
  logic                          fiq_s, fiq_en_q;
  logic [LVL_W-1:0]              thresh_q, win_l;
  logic [REG_W-1:0]              base_q, vec_q, vec_d;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic                          win_v, fire;
  logic [IDX_W-1:0]              win_i;

  vpic_sync #(.W(NUM_SRC + 1), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({fiq_i, irq_src_i}),
    .q_o    ({fiq_s, src_s})
  );

  vpic_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .prdata_o  (prdata_o),
    .thresh_o  (thresh_q),
    .base_o    (base_q),
    .en_o      (en_q),
    .sw_o      (sw_q),
    .fiq_en_o  (fiq_en_q),
    .lvl_o     (lvl_q),
    .vec_i     (vec_q),
    .pend_i    (pend)
  );

  assign pend = src_s | sw_q;
  assign qual = pend & en_q;

  vpic_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .req_i   (qual),
    .lvl_i   (lvl_q),
    .win_v_o (win_v),
    .win_l_o (win_l),
    .win_i_o (win_i)
  );

  assign fire  = win_v && (win_l > thresh_q);
  assign vec_d = fire ? base_q + (REG_W'(win_i) << 2) : base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_no <= 1'b1;
      fiq_no <= 1'b1;
      vec_q  <= '0;
    end else begin
      irq_no <= ~fire;
      fiq_no <= ~(fiq_s & fiq_en_q);
      vec_q  <= vec_d;
    end
  end

  // clockless so it works while clocks are stopped
  assign wake_o   = (|((irq_src_i | sw_q) & en_q)) | (fiq_i & fiq_en_q);
  assign pready_o = 1'b1;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
  import vpic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               psel_i,
  input logic               penable_i,
  input logic               pwrite_i,
  input logic [ADDR_W-1:0]  paddr_i,
  input logic               irq_no,
  input logic               fiq_no,
  input logic [31:0]        vec_i,
  input logic [31:0]        base_i,
  input logic               fiq_en_i,
  input logic [NUM_SRC-1:0] sw_i,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] en_i
);
  logic        sw_wr;
  logic [31:0] off;
  assign sw_wr = psel_i & penable_i & pwrite_i & (paddr_i == ADDR_W'(OFF_SW));
  assign off   = vec_i - base_i;

  assert_vec_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_no && $stable(base_i)) |-> (vec_i == base_i));

  assert_vec_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && $stable(base_i)) |-> (off[1:0] == 2'b00 && (off >> 2) < NUM_SRC));

  assert_sw_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_wr |=> $stable(sw_i));

  assert_fiq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_en_i |=> fiq_no);

  assert_irq_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> $past(|(pend_i & en_i)));
endmodule

bind vpic_channel vpic_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .irq_no    (irq_no),
  .fiq_no    (fiq_no),
  .vec_i     (vec_q),
  .base_i    (base_q),
  .fiq_en_i  (fiq_en_q),
  .sw_i      (sw_q),
  .pend_i    (pend),
  .en_i      (en_q)
);

// File: tb/sim_vpic_channel.sv
module sim_vpic_channel;
  localparam int N  = 12;
  localparam int AW = 8;

  logic          clk = 0, rst_n = 0;
  logic          psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0, prdata;
  logic          pready, irq_n, fiq_n, wake;
  logic [N-1:0]  src = '0;
  logic          fiq = 0;
  int            n_chk = 0, n_fail = 0;

  logic [3:0]    m_lvl [N];
  logic [N-1:0]  m_en;
  logic [3:0]    m_thr;

  always #5 clk = ~clk;

  vpic_channel #(.NUM_SRC(N), .LVL_W(4), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .irq_src_i(src), .fiq_i(fiq), .irq_no(irq_n),
    .fiq_no(fiq_n), .wake_o(wake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = AW'(a); pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = AW'(a); penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // expected vector offset index, -1 when nothing fires
  function automatic int model(logic [N-1:0] p);
    int best = -1; logic [3:0] bl = 0;
    for (int i = 0; i < N; i++)
      if (p[i] && m_en[i] && m_lvl[i] != 0 && m_lvl[i] > bl) begin
        best = i; bl = m_lvl[i];
      end
    return (best >= 0 && bl > m_thr) ? best : -1;
  endfunction

  task automatic cfg_all();
    wr('h08, 32'(m_en));
    wr('h00, 32'(m_thr));
    for (int i = 0; i < N; i++) wr('h40 + 4*i, 32'(m_lvl[i]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 irq_no", 32'(irq_n), 1);
    chk("R1 fiq_no", 32'(fiq_n), 1);
    chk("R1 wake", 32'(wake), 0);
    rst_n = 1;
    rd('h00, d); chk("R1 thresh", d, 0);
    rd('h04, d); chk("R1 base", d, 0);
    rd('h08, d); chk("R1 enable", d, 0);
    rd('h0C, d); chk("R1 swreq", d, 0);
    rd('h18, d); chk("R1 fiqen", d, 0);
    rd('h40 + 4*7, d); chk("R1 level7", d, 0);

    // R10 map, masking, unmapped, ready
    wr('h04, 32'hFFFF_FFFF); rd('h04, d); chk("R10/R5 base low bits", d, 32'hFFFF_FFFC);
    wr('h00, 32'hFFFF_FFFF); rd('h00, d); chk("R10 thresh width", d, 32'h0000_000F);
    rd('h30, d); chk("R10 unmapped", d, 0);
    rd('h40 + 4*N, d); chk("R10 beyond last level", d, 0);
    chk("R10 pready", 32'(pready), 1);

    wr('h04, 32'h0000_1000);
    for (int i = 0; i < N; i++) m_lvl[i] = 0;
    m_en = '1; m_thr = 0;
    // R6 hardware latency, R9 clockless wake
    m_lvl[2] = 3; cfg_all();
    @(negedge clk); src[2] = 1; #1;
    chk("R9 wake before any edge", 32'(wake), 1);
    @(posedge clk); @(negedge clk); chk("R6 edge1", 32'(irq_n), 1);
    @(posedge clk); @(negedge clk); chk("R6 edge2", 32'(irq_n), 1);
    @(posedge clk); @(negedge clk); chk("R6 edge3", 32'(irq_n), 0);
    rd('h10, d); chk("R5 vector src2", d, 32'h1008);
    rd('h14, d); chk("R2 pending", d, 32'h004);

    // R4 strict threshold
    wr('h00, 3); settle(); chk("R4 equal level blocked", 32'(irq_n), 1);
    rd('h10, d); chk("R5 idle vector is base", d, 32'h1000);
    wr('h00, 2); settle(); chk("R4 level above threshold", 32'(irq_n), 0);

    // R3 tie to lowest index, R2 disabled / level-0 ignored
    m_thr = 0; m_lvl[2] = 0; m_lvl[3] = 9; m_lvl[7] = 9; m_lvl[9] = 15;
    m_en = 12'hFFF & ~(12'h1 << 9); cfg_all();
    @(negedge clk); src = 12'h000; src[3] = 1; src[7] = 1; src[9] = 1; src[2] = 1;
    settle(); rd('h10, d); chk("R3 tie lowest index / R2 disabled", d, 32'h100C);
    src[9] = 0; src[3] = 0; settle();
    rd('h10, d); chk("R3 remaining source", d, 32'h101C);
    src = '0; settle(); chk("R2 level0 source ignored", 32'(irq_n), 1);
    src[2] = 1; settle(); chk("R2 level0 pending only", 32'(irq_n), 1);
    src = '0; m_en = '0; wr('h08, 0); src[7] = 1; #1;
    chk("R9 wake masked", 32'(wake), 0);
    settle(); chk("R2 disabled ignored", 32'(irq_n), 1);
    src = '0; m_en = '1; wr('h08, 32'hFFF);

    // R6 software latency, R7 stickiness
    @(negedge clk); psel = 1; pwrite = 1; paddr = 'h0C; pwdata = 32'h80; penable = 0;
    @(negedge clk); penable = 1;
    @(posedge clk); @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    chk("R6 sw write edge", 32'(irq_n), 1);
    @(posedge clk); @(negedge clk); chk("R6 sw next edge", 32'(irq_n), 0);
    chk("R9 wake from sw", 32'(wake), 1);
    repeat (10) @(posedge clk);
    rd('h0C, d); chk("R7 sw sticky", d, 32'h80);
    rd('h10, d); chk("R5 sw vector", d, 32'h101C);
    wr('h0C, 0); settle(); chk("R7 sw cleared", 32'(irq_n), 1);

    // R8 fast path
    @(negedge clk); fiq = 1; settle(); chk("R8 fiq disabled", 32'(fiq_n), 1);
    chk("R9 fiq without enable", 32'(wake), 0);
    fiq = 0; wr('h18, 1); wr('h00, 15);
    @(negedge clk); fiq = 1;
    @(posedge clk); @(posedge clk); @(negedge clk); chk("R8 fiq edge2", 32'(fiq_n), 1);
    @(posedge clk); @(negedge clk); chk("R8 fiq edge3 despite thresh 15", 32'(fiq_n), 0);
    fiq = 0; settle(); chk("R8 fiq release", 32'(fiq_n), 1);
    wr('h18, 0);

    // R2/R3/R4/R5 random
    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < N; i++) m_lvl[i] = 4'($urandom_range(0, 15));
      m_en  = N'($urandom);
      m_thr = 4'($urandom_range(0, 12));
      cfg_all();
      @(negedge clk); src = N'($urandom);
      settle();
      e = model(src);
      chk("R4 random irq", 32'(irq_n), (e < 0) ? 1 : 0);
      rd('h10, d);
      chk("R3/R5 random vector", d, 32'h1000 + ((e < 0) ? 0 : 4*e));
      rd('h14, d); chk("R2 random pending", d, 32'(src));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule